// File: doc/BRIEF.md
# Vertical Sync Rewrite Hazard Predictor

This block decides whether changing a CRT controller's vertical sync position register while the raster is active is likely to produce a spurious sync pulse. Each request carries three values: the register's current (old) value, the value about to be written (new), and the character row the controller is on. A variant bit picks one of two silicon models. The strict model needs all four bitwise conditions to hold. The relaxed model drops the fourth condition except in one case, described below. The block returns a hazard flag. It also returns the one row index at which this old/new pair is dangerous, so that software can schedule the rewrite on any other row.

Requests enter on a valid/ready stream and results leave on a valid/ready stream, one cycle after acceptance. The output stage holds one entry. A new request is accepted when the stage is empty or when its entry is being taken in the same cycle. While `out_ready` is low and a result is pending, `in_ready` stays low and the result is held unchanged.

Top module: `vsync_hazard_predictor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: In either variant, `hazard` is 0 unless three conditions all hold. (a) Row bits 2..0 equal old bits 2..0. (b) No bit in 6..3 is 1 in row while it is 0 in old. (c) In bits 6..3, wherever old is 1, new and row agree.
- R3: With `relaxed`=0, `hazard` is 1 exactly when the R2 conditions hold and (row & ~new & 0x0F) is zero.
- R4: With `relaxed`=1, the 0x0F condition of R3 is enforced only when old has exactly two of bits 6..3 set and row has both of those bits clear. Otherwise the R2 conditions alone set `hazard`.
- R5: Any request flagged with `relaxed`=0 is also flagged when the same values are sent with `relaxed`=1.
- R6: `unsafe_row` equals (old & new & 0x78) | (old & 0x07), in both variants.
- R7: Whenever `hazard` is 1, the request's row equals `unsafe_row`.
- R8: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid`=1 after that edge.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `hazard` and `unsafe_row` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| old_pos | input | 7 | Sync position value before the rewrite |
| new_pos | input | 7 | Sync position value being written |
| cur_row | input | 7 | Character row at the time of the rewrite |
| relaxed | input | 1 | 0 selects the strict model, 1 the relaxed model |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| hazard | output | 1 | Rewrite may emit a spurious sync pulse |
| unsafe_row | output | 7 | The single dangerous row for this old/new pair |

## Verification
The properties assume the following about the inputs. A request's fields are known whenever `in_valid` is high. Reset is held for at least one clock before it is released. `out_ready` may change freely at any time, and the result may sit in the output stage for any number of cycles. The stimulus drives only 7-bit values, keeps `in_valid` low during reset, and toggles `out_ready` at random so that stalls of varying length occur. It mixes random triples with rows chosen equal to the pair's unsafe row, so that the relaxation case and the 0x0F condition are both reached often.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
  localparam int unsigned VSH_DEF_WIDTH = 7;  // register and row width
  localparam int unsigned VSH_DEF_LOW   = 3;  // low bits that must match exactly
  localparam int unsigned VSH_DEF_C4    = 4;  // bits covered by the fourth condition

  typedef enum logic {
    MODEL_STRICT  = 1'b0,
    MODEL_RELAXED = 1'b1
  } model_e;
endpackage

// File: rtl/vsh_pair_exception.sv
// Detects the case where the relaxed model still enforces condition four:
// exactly two upper bits of the old value are set and both are clear in the row.
module vsh_pair_exception #(
  parameter int unsigned W   = vsh_pkg::VSH_DEF_WIDTH,
  parameter int unsigned LOW = vsh_pkg::VSH_DEF_LOW
) (
  input  logic [W-1:0] old_pos,
  input  logic [W-1:0] cur_row,
  output logic         keep_c4
);
  localparam int unsigned UP = W - LOW;

  logic [UP-1:0]    old_up;
  logic [UP-1:0]    row_up;
  logic [UP*UP-1:0] pair_hit;

  assign old_up = old_pos[W-1:LOW];
  assign row_up = cur_row[W-1:LOW];

  for (genvar gi = 0; gi < UP; gi++) begin : g_first
    for (genvar gj = 0; gj < UP; gj++) begin : g_second
      if (gj > gi) begin : g_pair
        localparam logic [UP-1:0] PAIR = (UP'(1) << gi) | (UP'(1) << gj);
        assign pair_hit[gi*UP+gj] = (old_up == PAIR) && !row_up[gi] && !row_up[gj];
      end else begin : g_none
        assign pair_hit[gi*UP+gj] = 1'b0;
      end
    end
  end

  assign keep_c4 = |pair_hit;
endmodule

// File: rtl/vsh_rule_eval.sv
// Evaluates the four bitwise conditions and combines them per model.
module vsh_rule_eval #(
  parameter int unsigned W   = vsh_pkg::VSH_DEF_WIDTH,
  parameter int unsigned LOW = vsh_pkg::VSH_DEF_LOW,
  parameter int unsigned C4  = vsh_pkg::VSH_DEF_C4
) (
  input  logic [W-1:0]   old_pos,
  input  logic [W-1:0]   new_pos,
  input  logic [W-1:0]   cur_row,
  input  vsh_pkg::model_e model,
  output logic           hazard
);
  localparam logic [W-1:0] LOW_M = W'((1 << LOW) - 1);
  localparam logic [W-1:0] UP_M  = ~LOW_M;
  localparam logic [W-1:0] C4_M  = W'((1 << C4) - 1);

  logic low_match;
  logic row_within_old;
  logic tracked_agree;
  logic no_extra_low;
  logic keep_c4;
  logic c4_ok;

  assign low_match      = ((cur_row ^ old_pos) & LOW_M) == '0;
  assign row_within_old = (cur_row & ~old_pos & UP_M) == '0;
  assign tracked_agree  = (old_pos & (new_pos ^ cur_row) & UP_M) == '0;
  assign no_extra_low   = (cur_row & ~new_pos & C4_M) == '0;

  vsh_pair_exception #(.W(W), .LOW(LOW)) u_pair (
    .old_pos (old_pos),
    .cur_row (cur_row),
    .keep_c4 (keep_c4)
  );

  always_comb begin
    unique case (model)
      vsh_pkg::MODEL_STRICT:  c4_ok = no_extra_low;
      vsh_pkg::MODEL_RELAXED: c4_ok = no_extra_low || !keep_c4;
      default:                c4_ok = no_extra_low;
    endcase
  end

  assign hazard = low_match && row_within_old && tracked_agree && c4_ok;
endmodule

// File: rtl/vsh_unsafe_row.sv
// The only row on which a given old/new pair can glitch.
module vsh_unsafe_row #(
  parameter int unsigned W   = vsh_pkg::VSH_DEF_WIDTH,
  parameter int unsigned LOW = vsh_pkg::VSH_DEF_LOW
) (
  input  logic [W-1:0] old_pos,
  input  logic [W-1:0] new_pos,
  output logic [W-1:0] danger_row
);
  localparam logic [W-1:0] LOW_M = W'((1 << LOW) - 1);
  localparam logic [W-1:0] UP_M  = ~LOW_M;

  assign danger_row = (old_pos & new_pos & UP_M) | (old_pos & LOW_M);
endmodule

// File: rtl/vsh_out_stage.sv
// One-entry registered output with valid/ready on both sides.
module vsh_out_stage #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          valid_q;
  logic [PW-1:0] data_q;

  assign in_ready  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end
endmodule

// File: rtl/vsync_hazard_predictor.sv
module vsync_hazard_predictor #(
  parameter int unsigned W   = vsh_pkg::VSH_DEF_WIDTH,
  parameter int unsigned LOW = vsh_pkg::VSH_DEF_LOW,
  parameter int unsigned C4  = vsh_pkg::VSH_DEF_C4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] old_pos,
  input  logic [W-1:0] new_pos,
  input  logic [W-1:0] cur_row,
  input  logic         relaxed,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         hazard,
  output logic [W-1:0] unsafe_row
);
  localparam int unsigned PW = W + 1;

  logic          haz_c;
  logic [W-1:0]  row_c;
  logic [PW-1:0] res_d;
  logic [PW-1:0] res_q;
  vsh_pkg::model_e model;

  assign model = relaxed ? vsh_pkg::MODEL_RELAXED : vsh_pkg::MODEL_STRICT;

  vsh_rule_eval #(.W(W), .LOW(LOW), .C4(C4)) u_rules (
    .old_pos (old_pos),
    .new_pos (new_pos),
    .cur_row (cur_row),
    .model   (model),
    .hazard  (haz_c)
  );

  vsh_unsafe_row #(.W(W), .LOW(LOW)) u_row (
    .old_pos    (old_pos),
    .new_pos    (new_pos),
    .danger_row (row_c)
  );

  assign res_d = {haz_c, row_c};

  vsh_out_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign hazard     = res_q[PW-1];
  assign unsafe_row = res_q[W-1:0];
endmodule

// File: rtl/vsh_checker.sv
module vsh_checker #(
  parameter int unsigned W   = vsh_pkg::VSH_DEF_WIDTH,
  parameter int unsigned LOW = vsh_pkg::VSH_DEF_LOW,
  parameter int unsigned C4  = vsh_pkg::VSH_DEF_C4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] old_pos,
  input logic [W-1:0] new_pos,
  input logic [W-1:0] cur_row,
  input logic         relaxed,
  input logic         out_valid,
  input logic         out_ready,
  input logic         hazard,
  input logic [W-1:0] unsafe_row
);
  localparam logic [W-1:0] LOW_M = W'((1 << LOW) - 1);
  localparam logic [W-1:0] C4_M  = W'((1 << C4) - 1);

  // R8: an accepted request yields a valid result after the edge
  a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: a stalled result holds still
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(hazard) && $stable(unsafe_row)));

  // R9: an empty stage always accepts
  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6: the unsafe row keeps the old value's low bits
  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((unsafe_row & LOW_M) == ($past(old_pos) & LOW_M)));

  // R7: a flagged request sits on the unsafe row
  a_r7_row_match: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!hazard || unsafe_row == $past(cur_row)));

  // R3: the strict model never flags when condition four fails
  a_r3_strict_c4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !relaxed) |=>
      (!hazard || (($past(cur_row) & ~$past(new_pos) & C4_M) == '0)));
endmodule

bind vsync_hazard_predictor vsh_checker #(.W(W), .LOW(LOW), .C4(C4)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .old_pos    (old_pos),
  .new_pos    (new_pos),
  .cur_row    (cur_row),
  .relaxed    (relaxed),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .hazard     (hazard),
  .unsafe_row (unsafe_row)
);

// File: tb/vsync_hazard_predictor_tb.sv
module vsync_hazard_predictor_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [6:0] old_pos = '0;
  logic [6:0] new_pos = '0;
  logic [6:0] cur_row = '0;
  logic       relaxed = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       hazard;
  logic [6:0] unsafe_row;

  int n_checks = 0;
  int n_fail = 0;

  // behavioural reference state
  bit exp_v = 0;
  bit exp_h = 0;
  int exp_row = 0;
  int exp_req_row = 0;
  string exp_tag = "R3";
  bit last_h = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_hazard_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .old_pos(old_pos), .new_pos(new_pos), .cur_row(cur_row), .relaxed(relaxed),
    .out_valid(out_valid), .out_ready(out_ready), .hazard(hazard), .unsafe_row(unsafe_row)
  );

  function automatic int ones_upper(int v);
    int n = 0;
    for (int b = 3; b <= 6; b++) if (v[b]) n++;
    return n;
  endfunction

  function automatic bit base_ok(int f, int t, int r);
    return ((r & 7) == (f & 7)) && ((r & ~f & 'h78) == 0) && ((f & (t ^ r) & 'h78) == 0);
  endfunction

  function automatic bit ref_hazard(int f, int t, int r, bit rel);
    bit c4 = ((r & ~t & 'h0F) == 0);
    bit enforce = (ones_upper(f) == 2) && ((f & r & 'h78) == 0);
    if (!base_ok(f, t, r)) return 0;
    if (!rel) return c4;
    return c4 || !enforce;
  endfunction

  function automatic int ref_row(int f, int t);
    return (f & t & 'h78) | (f & 7);
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive, check ready, edge, update model, check outputs
  task automatic cycle(bit iv, int f, int t, int r, bit rel, bit ordy);
    bit acc;
    in_valid = iv; old_pos = 7'(f); new_pos = 7'(t); cur_row = 7'(r);
    relaxed = rel; out_ready = ordy;
    #1;
    check("R9 in_ready", int'(in_ready), int'(!exp_v || ordy));
    @(posedge clk);
    acc = iv && (!exp_v || ordy);
    if (exp_v && ordy) exp_v = 0;
    if (acc) begin
      exp_v = 1;
      exp_h = ref_hazard(f, t, r, rel);
      exp_row = ref_row(f, t);
      exp_req_row = r;
      exp_tag = !base_ok(f, t, r) ? "R2 hazard" : (rel ? "R4 hazard" : "R3 hazard");
    end
    @(negedge clk);
    check("R8 out_valid", int'(out_valid), int'(exp_v));
    if (exp_v) begin
      check(exp_tag, int'(hazard), int'(exp_h));
      check("R6 unsafe_row", int'(unsafe_row), exp_row);
      if (hazard) check("R7 row equals unsafe_row", exp_req_row, int'(unsafe_row));
      last_h = hazard;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R2: low bits differ -> no hazard in either model
    cycle(1, 'h05, 'h05, 'h04, 1, 1);
    cycle(1, 'h05, 'h05, 'h04, 0, 1);
    // R3/R4: old=0x18 (two upper bits), new=0x00, row=0x00 -> c4 enforced; row&~new&0xF=0 -> hazard both
    cycle(1, 'h18, 'h00, 'h00, 0, 1);
    cycle(1, 'h18, 'h00, 'h00, 1, 1);
    // R4: old=0x0F new=0x08 row=0x0F? c4 fails (bits 2..0 in row, not new); one upper bit -> relaxed flags
    cycle(1, 'h0F, 'h08, 'h0F, 0, 1);
    cycle(1, 'h0F, 'h08, 'h0F, 1, 1);
    // R4 exception: old=0x1F (bits3,4) new=0x00 row=0x07: c4 fails, enforced -> no hazard
    cycle(1, 'h1F, 'h00, 'h07, 1, 1);

    // R9: stall with a pending result
    cycle(1, 'h7F, 'h7F, 'h7F, 1, 0);
    for (int k = 0; k < 4; k++) cycle(1, k, k, k, 0, 0);
    cycle(0, 0, 0, 0, 0, 1);

    // R5: same triple through both models
    for (int k = 0; k < 400; k++) begin
      int f = $urandom_range(0, 127);
      int t = $urandom_range(0, 127);
      int r = (k % 2 == 0) ? ref_row(f, t) : $urandom_range(0, 127);
      bit hs;
      cycle(1, f, t, r, 0, 1);
      hs = last_h;
      cycle(1, f, t, r, 1, 1);
      if (hs) check("R5 relaxed covers strict", int'(last_h), 1);
    end

    // random traffic with back-pressure
    for (int k = 0; k < 4000; k++) begin
      int f = $urandom_range(0, 127);
      int t = $urandom_range(0, 127);
      int r = ($urandom_range(0, 2) != 0) ? ref_row(f, t) : $urandom_range(0, 127);
      cycle(bit'($urandom_range(0, 3) != 0), f, t, r, bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 2) != 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule